// File: doc/BRIEF.md
# UART baud rate generator

This block produces the timing enables for a serial port. One configuration byte holds a two-bit prescaler code and a three-bit rate exponent, and together they set a single bit rate that the receiver and the transmitter share. The module clock is divided by the coded prescaler (1, 3, 4 or 13), then by a power of two (2^N, N = 0..7), then by 4. The result is a one-cycle enable at sixteen times the bit rate for the receiver's sampler. Every sixteenth of those enables is also the one-cycle bit-rate enable for the transmitter.

A single-register read/write port loads and reads back the configuration. Every write restarts all dividers from a clean phase. A two-state control machine (`CTRL_LOAD`, `CTRL_RUN`) sequences this. Reset, or a write, puts the machine in `CTRL_LOAD` (transition "reload"). There the counters take their terminal values from the new configuration for one cycle. The machine then moves to `CTRL_RUN` (transition "start") and counts freely. A write during `CTRL_RUN` returns it to `CTRL_LOAD`. A write during `CTRL_LOAD` keeps it there.

Top module: `uart_baud_gen`

## Requirements
- R1: Configuration bits 5:4 select the prescaler divisor PD: code 0 gives 1, code 1 gives 3, code 2 gives 4, code 3 gives 13.
- R2: Configuration bits 2:0 hold N, and the divider after the prescaler divides by 2^N.
- R3: After a write sampled at clock edge e0, `rx_tick` is high exactly in the cycles that follow edges e0+1+k·P for k ≥ 1, where P = 4·PD·2^N.
- R4: `tx_tick` is high exactly in the cycles that follow edges e0+1+16·k·P for k ≥ 1. Each `tx_tick` coincides with an `rx_tick`, and both come from the one configuration.
- R5: `rd_data` returns bits 5:4 and 2:0 as last written. Bits 7, 6 and 3 always read 0, and writes to them are ignored.
- R6: While reset is held, `rd_data` reads 0 and both enables are low. After release the divisors are 1 and 1. `rx_tick` follows the first edge e_r after release by 4·k cycles, and `tx_tick` by 64·k cycles.
- R7: A write restarts the phase. No enable appears in the cycle after the write edge or in the load cycle, whatever phase the old rate was in.
- R8: Every `rx_tick` and `tx_tick` pulse is exactly one clock cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the configuration byte |
| wr_data | input | 8 | Configuration byte to write |
| rd_data | output | 8 | Current configuration readback |
| rx_tick | output | 1 | One-cycle enable at 16x the bit rate |
| tx_tick | output | 1 | One-cycle enable at the bit rate |

## Verification
Readback is due one edge after the write edge. The first receiver enable is due P+1 edges after it, and the first transmitter enable 16·P+1 edges after it. After every write, the bench counts edges from the write edge and samples at each falling edge. It compares both enables against the exact cycle predicted from its own period formula, in every cycle of the window, so an early, late, missing or wide pulse is caught. For the slowest settings the window covers two receiver periods instead of a full transmitter period.

// File: rtl/uart_baud_pkg.sv
package uart_baud_pkg;

    parameter int CFG_W  = 8;
    parameter int PSEL_W = 2;
    parameter int RSEL_W = 3;
    parameter int PSEL_LSB = 4;
    parameter int RSEL_LSB = 0;

    localparam int MAX_SHIFT = (1 << RSEL_W) - 1;
    localparam int CNT_W = (MAX_SHIFT > 8) ? MAX_SHIFT : 8;

    localparam logic [CFG_W-1:0] CFG_WR_MASK =
        CFG_W'(((1 << PSEL_W) - 1) << PSEL_LSB) |
        CFG_W'(((1 << RSEL_W) - 1) << RSEL_LSB);

    typedef enum logic {
        CTRL_LOAD = 1'b0,
        CTRL_RUN  = 1'b1
    } ctrl_state_t;

    function automatic logic [CNT_W-1:0] prescale_div(input logic [PSEL_W-1:0] code);
        logic [CNT_W-1:0] d;
        unique case (code)
            2'd0:    d = CNT_W'(1);
            2'd1:    d = CNT_W'(3);
            2'd2:    d = CNT_W'(4);
            default: d = CNT_W'(13);
        endcase
        return d;
    endfunction

endpackage

// File: rtl/uart_baud_divstage.sv
module uart_baud_divstage #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             en_in,
    input  logic [CNT_W-1:0] load_val,
    output logic             en_out
);
    logic [CNT_W-1:0] cnt;

    assign en_out = en_in && (cnt == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (en_in) begin
            if (cnt == '0) cnt <= load_val;
            else           cnt <= cnt - 1'b1;
        end
    end

    // R7: a load places the stage at its terminal value
    assert_stage_loaded_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt == $past(load_val)));

    // R3: a running counter never exceeds its reload value
    assert_stage_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !$past(load)) |-> (cnt <= load_val));
endmodule

// File: rtl/uart_baud_ctrl.sv
module uart_baud_ctrl
    import uart_baud_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    output logic [CFG_W-1:0] cfg,
    output logic             load,
    output logic             run
);
    ctrl_state_t state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            CTRL_LOAD: state_nx = wr_en ? CTRL_LOAD : CTRL_RUN;
            CTRL_RUN:  state_nx = wr_en ? CTRL_LOAD : CTRL_RUN;
            default:   state_nx = CTRL_LOAD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= CTRL_LOAD;
        else        state <= state_nx;
    end

    always_comb begin
        load = 1'b0;
        run  = 1'b0;
        unique case (state)
            CTRL_LOAD: load = 1'b1;
            CTRL_RUN:  run  = 1'b1;
            default:   load = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     cfg <= '0;
        else if (wr_en) cfg <= wr_data & CFG_WR_MASK;
    end

    // R5: writes land one edge later with unimplemented bits dropped
    assert_cfg_written_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (cfg == ($past(wr_data) & CFG_WR_MASK)));

    // R7: any write sends the controller into the load state
    assert_write_reloads_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> load);

    // R7: load never lasts past a cycle without a write
    assert_load_leaves_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !wr_en) |=> run);
endmodule

// File: rtl/uart_baud_gen.sv
module uart_baud_gen
    import uart_baud_pkg::*;
#(
    parameter int SUB_DIV = 4,
    parameter int OVS_DIV = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    output logic       rx_tick,
    output logic       tx_tick
);
    localparam int NSTAGE = 4;

    logic [CFG_W-1:0]  cfg;
    logic              load, run;
    logic [PSEL_W-1:0] psel;
    logic [RSEL_W-1:0] rsel;
    logic [CNT_W-1:0]  reload [NSTAGE];
    logic [NSTAGE:0]   en;
    logic              rx_q, tx_q;

    uart_baud_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .cfg     (cfg),
        .load    (load),
        .run     (run)
    );

    assign psel = cfg[PSEL_LSB +: PSEL_W];
    assign rsel = cfg[RSEL_LSB +: RSEL_W];

    assign reload[0] = prescale_div(psel) - 1'b1;
    assign reload[1] = (CNT_W'(1) << rsel) - 1'b1;
    assign reload[2] = CNT_W'(SUB_DIV - 1);
    assign reload[3] = CNT_W'(OVS_DIV - 1);

    assign en[0] = run;

    for (genvar i = 0; i < NSTAGE; i++) begin : g_stage
        uart_baud_divstage #(.CNT_W(CNT_W)) u_stage (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (load),
            .en_in    (en[i]),
            .load_val (reload[i]),
            .en_out   (en[i+1])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_q <= 1'b0;
            tx_q <= 1'b0;
        end else begin
            rx_q <= en[NSTAGE-1] && !wr_en;
            tx_q <= en[NSTAGE]   && !wr_en;
        end
    end

    assign rx_tick = rx_q;
    assign tx_tick = tx_q;
    assign rd_data = cfg;

    // R8: enables are single-cycle pulses
    assert_rx_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_tick |=> !rx_tick);
    assert_tx_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_tick |=> !tx_tick);

    // R4: bit-rate enable always lines up with a sample enable
    assert_tx_on_rx_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_tick |-> rx_tick);

    // R7: no enable right after a write
    assert_no_runt_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (!rx_tick && !tx_tick));

    // R5: unimplemented bits read zero
    assert_rsvd_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data & ~CFG_WR_MASK) == '0);
endmodule

// File: tb/tb_uart_baud_gen.sv
module tb_uart_baud_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       rx_tick, tx_tick;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    uart_baud_gen dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .rx_tick(rx_tick), .tx_tick(tx_tick)
    );

    // R1 divisor table
    function automatic int exp_pd(input logic [7:0] c);
        case (c[5:4])
            2'd0: return 1;
            2'd1: return 3;
            2'd2: return 4;
            default: return 13;
        endcase
    endfunction

    // R3: sample period; R2 adds 2^N
    function automatic int exp_period(input logic [7:0] c);
        return 4 * exp_pd(c) * (1 << c[2:0]);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // j counts edges after the reference edge; pulses expected at base+kP
    task automatic watch(input int p, input int len, input int base, input string tag);
        for (int j = 0; j <= len; j++) begin
            bit e_rx, e_tx;
            int d;
            if (j > 0) @(negedge clk);
            d = j - base;
            e_rx = (d >= p) && (d % p == 0);
            e_tx = (d >= 16 * p) && (d % (16 * p) == 0);
            check(rx_tick == e_rx, {tag, " R3 R1 R2 R8 rx"}, rx_tick, e_rx);
            check(tx_tick == e_tx, {tag, " R4 R8 tx"}, tx_tick, e_tx);
        end
    endtask

    task automatic write_cfg(input logic [7:0] v);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run_cfg(input logic [7:0] v, input string tag);
        int p, len;
        write_cfg(v);
        check(rd_data == (v & 8'h37), {tag, " R5 readback"}, rd_data, v & 8'h37);
        p = exp_period(v);
        len = (16 * p + 2 <= 6000) ? 16 * p + 2 : 2 * p + 2;
        watch(p, len, 1, tag);
    endtask

    initial begin : wdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog R3 actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'd7021));
        // R6: reset state
        repeat (3) @(negedge clk);
        check(rd_data == 8'h00, "R6 reset readback", rd_data, 0);
        check(rx_tick == 1'b0, "R6 reset rx", rx_tick, 0);
        check(tx_tick == 1'b0, "R6 reset tx", tx_tick, 0);
        rst_n = 1'b1;
        @(negedge clk);
        watch(4, 66, 0, "R6 post-reset");

        // R5: unimplemented bits ignored, all-ones write
        write_cfg(8'hFF);
        check(rd_data == 8'h37, "R5 mask ff", rd_data, 8'h37);
        write_cfg(8'hC8);
        check(rd_data == 8'h00, "R5 mask c8", rd_data, 0);

        // R1: each prescaler code; R2: rate extremes
        run_cfg(8'h00, "dir pd1");
        run_cfg(8'h10, "dir pd3");
        run_cfg(8'h20, "dir pd4");
        run_cfg(8'h30, "dir pd13");
        run_cfg(8'h03, "dir n3");
        run_cfg(8'h37, "dir slowest");

        // R7: rewrite mid-phase, including same value
        write_cfg(8'h11);
        repeat (37) @(negedge clk);
        run_cfg(8'h02, "R7 midphase");
        repeat (5) @(negedge clk);
        run_cfg(8'h02, "R7 same value");
        write_cfg(8'h00);
        repeat (3) @(negedge clk);
        run_cfg(8'h21, "R7 near pulse");

        // random configurations
        for (int i = 0; i < 10; i++) begin
            logic [7:0] v;
            v = 8'($urandom);
            if (v[2:0] > 3'd4) v[2:0] = 3'($urandom_range(0, 4));
            run_cfg(v, "rand");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule